// File: doc/BRIEF.md
# Walk-Cache Corrected-Error Status Record

This block holds the status record for corrected errors found in the walk caches of an address translation unit. Eight walk caches can report an error. Each report carries a valid strobe, a 3-bit source index and a one-bit kind flag that says whether the tag or the data was corrupted. The record keeps the syndrome and the source of the earliest error that software has not yet acknowledged. When further reports arrive on top of that error, it raises an overflow flag and leaves the stored syndrome unchanged.

Software sees the record as one 32-bit word on a plain register read/write port. It acknowledges the record through write-one-to-clear fields, and these clears are interlocked:
- The overflow flag must be cleared before, or in the same write as, the corrected-error field.
- The corrected-error field must be cleared before, or in the same write as, the valid flag.

Clearing the valid flag empties the syndrome. A single write of 0x4B000000 acknowledges the whole record at once.

Top module: `ras_err_record`

## Requirements
- R1: After synchronous reset every field is zero, so a read of the record returns 0x00000000.
- R2: Read word layout: valid flag at bit 30, overflow at bit 27, corrected-error field at bits 25:24, source code at bits 15:8, syndrome at bits 7:0. Bits 31, 29:28, 26 and 23:16 always read 0.
- R3: A report accepted while valid is clear loads the following and clears overflow:
  - syndrome 0x07 for a tag fault (kind 0) or 0x08 for a data fault (kind 1);
  - source code equal to the source index, where 0-3 are stage-1 levels 0-3 and 4-7 are stage-2 levels 0-3;
  - valid set to 1 and the corrected-error field set to 2'b10.
- R4: A report that arrives while valid is set, and is not met by an effective clear of valid, sets overflow. Syndrome, source code and the corrected-error field keep their values.
- R5: Writing 1 to bit 27 clears overflow. Writing 0 there leaves it unchanged.
- R6: The corrected-error field clears only when bits 25:24 are written as 2'b11, and any other value leaves it unchanged. That clear is ignored while overflow is 1, unless the same write also sets bit 27.
- R7: Writing 1 to bit 30 clears valid. The clear is ignored while the corrected-error field is nonzero, unless the same write also clears that field effectively.
- R8: An effective clear of valid returns the syndrome and the source code to 0x00.
- R9: Register writes never change the syndrome or the source code directly, whatever is written into bits 15:0.
- R10: When a report and an effective clear of valid fall in the same cycle, the report wins. The record then holds the new error with valid 1, corrected-error field 2'b10 and overflow 0.
- R11: Read data appears one clock after a read strobe to offset 0x8E90 and stays registered. A read of any other offset returns 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_valid | input | 1 | Error report strobe |
| err_src | input | 3 | Walk-cache index of the report |
| err_kind | input | 1 | 0 = tag corrupted, 1 = data corrupted |

## Verification
A hardware error report and a software acknowledge write can land in the same clock edge. The bench provokes this by driving err_valid together with a full-acknowledge write in one cycle. It judges the outcome by reading back the record, which must hold the new source and syndrome with overflow clear. A second collision, where a report meets a write whose valid clear is blocked, must leave the earliest syndrome in place and raise overflow.

// File: rtl/ras_rec_pkg.sv
package ras_rec_pkg;

  // Field positions the reader decodes
  localparam int POS_VALID = 30;
  localparam int POS_OVF   = 27;
  localparam int POS_CE_LO = 24;
  localparam int POS_SRC   = 8;
  localparam int POS_SYN   = 0;

  localparam logic [1:0] CE_NONE = 2'b00;
  localparam logic [1:0] CE_REC  = 2'b10;
  localparam logic [1:0] CE_ACK  = 2'b11;

  localparam logic [7:0] SYN_NONE = 8'h00;
  localparam logic [7:0] SYN_TAG  = 8'h07;
  localparam logic [7:0] SYN_DATA = 8'h08;

  typedef struct packed {
    logic       valid;
    logic       ovf;
    logic [1:0] ce;
    logic [7:0] src;
    logic [7:0] syn;
  } rec_t;

  function automatic logic [31:0] pack_rec(input rec_t r);
    logic [31:0] w;
    w = '0;
    w[POS_VALID]            = r.valid;
    w[POS_OVF]              = r.ovf;
    w[POS_CE_LO +: 2]       = r.ce;
    w[POS_SRC +: 8]         = r.src;
    w[POS_SYN +: 8]         = r.syn;
    return w;
  endfunction

endpackage

// File: rtl/ras_acc_decode.sv
module ras_acc_decode #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] REG_OFS = 16'h8E90
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic match;
  always_comb begin
    match  = (addr == REG_OFS);
    wr_hit = wr_en & match;
    rd_hit = rd_en & match;
  end
endmodule

// File: rtl/ras_rec_core.sv
module ras_rec_core
  import ras_rec_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             w_valid,
  input  logic             w_ovf,
  input  logic [1:0]       w_ce,
  input  logic             err_valid,
  input  logic [SRC_W-1:0] err_src,
  input  logic             err_kind,
  output rec_t             rec
);
  localparam int SRC_PAD = 8 - SRC_W;

  logic clr_ovf, clr_ce, clr_valid;
  logic [7:0] new_syn, new_src;

  always_comb begin
    clr_ovf   = wr_hit & w_ovf;
    clr_ce    = wr_hit & (w_ce == CE_ACK) & (~rec.ovf | clr_ovf);
    clr_valid = wr_hit & w_valid & ((rec.ce == CE_NONE) | clr_ce);
    new_syn   = err_kind ? SYN_DATA : SYN_TAG;
    new_src   = {{SRC_PAD{1'b0}}, err_src};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec <= '0;
    end else if (err_valid && (!rec.valid || clr_valid)) begin
      rec.valid <= 1'b1;
      rec.ovf   <= 1'b0;
      rec.ce    <= CE_REC;
      rec.src   <= new_src;
      rec.syn   <= new_syn;
    end else begin
      if (err_valid)      rec.ovf <= 1'b1;
      else if (clr_ovf)   rec.ovf <= 1'b0;
      if (clr_ce)         rec.ce  <= CE_NONE;
      if (clr_valid) begin
        rec.valid <= 1'b0;
        rec.src   <= SYN_NONE;
        rec.syn   <= SYN_NONE;
      end
    end
  end

  // R3: a corrected-error field is only ever held together with valid
  p_ce_implies_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (rec.ce != CE_NONE) |-> rec.valid);

  // R8: an empty record carries no syndrome
  p_empty_no_syn_r8: assert property (@(posedge clk) disable iff (rst)
    !rec.valid |-> (rec.syn == SYN_NONE && rec.src == 8'h00));

  // R4: a report on a held record raises overflow
  p_second_err_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (err_valid && rec.valid && !(wr_hit && w_valid)) |=> rec.ovf);

  // R7: valid clear blocked while CE remains
  p_valid_interlock_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && w_valid && rec.ce != CE_NONE && w_ce != CE_ACK) |=> rec.valid);

  // R6: CE clear blocked while overflow remains
  p_ce_interlock_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && w_ce == CE_ACK && rec.ovf && !w_ovf && rec.ce != CE_NONE)
      |=> (rec.ce != CE_NONE));

  // R9: syndrome holds unless a report arrives or valid is written
  p_syn_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!err_valid && !(wr_hit && w_valid)) |=> ($stable(rec.syn) && $stable(rec.src)));
endmodule

// File: rtl/ras_rd_port.sv
module ras_rd_port
  import ras_rec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  rec_t              rec,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= pack_rec(rec);
    else             rdata <= '0;
  end

  // R2: reserved bits never read as 1
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rdata[31] == 1'b0 && rdata[29:28] == 2'b00 && rdata[26] == 1'b0 && rdata[23:16] == 8'h00));

  // R11: a cycle without a hit returns zero next cycle
  p_miss_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rdata == '0));
endmodule

// File: rtl/ras_err_record.sv
module ras_err_record
  import ras_rec_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] REG_OFS = 16'h8E90,
  parameter int                SRC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              err_valid,
  input  logic [SRC_W-1:0]  err_src,
  input  logic              err_kind
);
  logic wr_hit, rd_hit;
  rec_t rec;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[31], wdata[29:28], wdata[26], wdata[23:0]};

  ras_acc_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  ras_rec_core #(.SRC_W(SRC_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .w_valid  (wdata[POS_VALID]),
    .w_ovf    (wdata[POS_OVF]),
    .w_ce     (wdata[POS_CE_LO +: 2]),
    .err_valid(err_valid),
    .err_src  (err_src),
    .err_kind (err_kind),
    .rec      (rec)
  );

  ras_rd_port #(.DATA_W(32)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_hit(rd_hit),
    .rec   (rec),
    .rdata (rdata)
  );
endmodule

// File: tb/sim_ras_err_record.sv
module sim_ras_err_record;
  localparam logic [15:0] OFS = 16'h8E90;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, err_valid, err_kind;
  logic [15:0] addr;
  logic [31:0] wdata, rdata;
  logic [2:0]  err_src;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ras_err_record u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_valid(err_valid),
    .err_src(err_src), .err_kind(err_kind)
  );

  function automatic logic [31:0] word(input logic v, input logic o,
      input logic [1:0] ce, input logic [7:0] src, input logic [7:0] syn);
    return {1'b0, v, 2'b00, o, 1'b0, ce, 8'h00, src, syn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic report(input logic [2:0] s, input logic k);
    @(negedge clk); err_valid = 1'b1; err_src = s; err_kind = k;
    @(negedge clk); err_valid = 1'b0;
  endtask

  task automatic expect_rec(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(OFS, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    expect_rec("R1 reset", 32'h0);
  endtask

  task automatic t_first_second;
    report(3'd5, 1'b1);
    expect_rec("R3/R2 first data error", word(1, 0, 2'b10, 8'h05, 8'h08));
    report(3'd2, 1'b0);
    expect_rec("R4 second error keeps first", word(1, 1, 2'b10, 8'h05, 8'h08));
  endtask

  task automatic t_ignored_writes;
    wr(OFS, 32'h9370_FFFF);
    expect_rec("R9/R5 low bits and zero OF write ignored", word(1, 1, 2'b10, 8'h05, 8'h08));
    wr(OFS, 32'h0300_0000);
    expect_rec("R6 CE clear blocked by OF", word(1, 1, 2'b10, 8'h05, 8'h08));
    wr(OFS, 32'h4000_0000);
    expect_rec("R7 V clear blocked by CE", word(1, 1, 2'b10, 8'h05, 8'h08));
    wr(16'h8E94, 32'hFFFF_FFFF);
    expect_rec("R11 other offset write ignored", word(1, 1, 2'b10, 8'h05, 8'h08));
  endtask

  task automatic t_ordered_ack;
    wr(OFS, 32'h0A00_0000);
    expect_rec("R5/R6 OF cleared, CE 10 ignored", word(1, 0, 2'b10, 8'h05, 8'h08));
    wr(OFS, 32'h0300_0000);
    expect_rec("R6 CE cleared", word(1, 0, 2'b00, 8'h05, 8'h08));
    wr(OFS, 32'h4000_0000);
    expect_rec("R7/R8 V cleared and record empty", 32'h0);
  endtask

  task automatic t_single_ack;
    report(3'd0, 1'b0);
    expect_rec("R3 tag error stage1 level0", word(1, 0, 2'b10, 8'h00, 8'h07));
    report(3'd6, 1'b1);
    wr(OFS, 32'h4B00_0000);
    expect_rec("R7 one-write ack with OF", 32'h0);
  endtask

  task automatic t_collision;
    report(3'd7, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; addr = OFS; wdata = 32'h4B00_0000;
    err_valid = 1'b1; err_src = 3'd3; err_kind = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; err_valid = 1'b0; wdata = '0;
    expect_rec("R10 new error wins over ack", word(1, 0, 2'b10, 8'h03, 8'h07));
    @(negedge clk);
    wr_en = 1'b1; addr = OFS; wdata = 32'h4000_0000;
    err_valid = 1'b1; err_src = 3'd1; err_kind = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_valid = 1'b0; wdata = '0;
    expect_rec("R4 report with blocked V clear", word(1, 1, 2'b10, 8'h03, 8'h07));
  endtask

  task automatic t_other_read;
    logic [31:0] d;
    rd(16'h8E80, d);
    chk("R11 other offset reads zero", d, 32'h0);
    @(negedge clk);
    chk("R11 idle read data zero", rdata, 32'h0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; err_valid = 0; err_kind = 0;
    err_src = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_second();
    t_ignored_writes();
    t_ordered_ack();
    t_single_ack();
    t_collision();
    t_other_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule